// File: doc/BRIEF.md
# Real-Time-Clock Register File

This block is the software-visible register set of a real-time-clock peripheral. A word-addressed 32-bit bus reads and writes a packed calendar-date word, a packed time-of-day word, a control word that carries two sticky update flags, and a bank of scratch words. Firmware sets the clock by writing the date and time words. It learns that a new setting has been taken by polling the control word, and that read also clears the flags. A one-cycle pulse at a one-second rate advances the time word.

The date word holds the day of month in its low byte, the month (1..12) in the next byte, and the year in the upper half, counted from a base year (the `BASE_YEAR` parameter). The time word holds seconds in bits [7:0], minutes in [15:8], hours in [23:16] and the weekday in [31:29], where Monday is 0 and Sunday is 6. The `MAP_VARIANT` parameter chooses one of two address layouts. Variant 0 is compact and has four scratch words. Variant 1 is spread out and has eight scratch words. The window covers 1 KiB. An access to a hole or to an unaligned byte address is harmless and is reported on an error strobe.

Top module: `rtc_regfile`

## Requirements
- R1: After synchronous reset, every register reads as zero, and `rd_valid` and `bus_err` are low until the first access.
- R2: A write to the date word stores the written value and sets control bit 7. A write to the time word stores the written value and sets control bit 8.
- R3: A read of the control word returns bit 7 and bit 8 as they stood before the read, and clears both bits in that same access, so a second read returns zero.
- R4: A write to the control word changes nothing: the flags keep their values.
- R5: A read access returns `rd_valid` high together with its `rd_data` exactly one clock later. A write never raises `rd_valid`.
- R6: Scratch words are plain storage. A read of a scratch word returns the last value written to it and leaves the update flags unchanged.
- R7: An access to an unmapped or unaligned offset pulses `bus_err` one cycle later. A read of such an offset returns zero. A write to such an offset changes no register.
- R8: With variant 0 the offsets are: control 0x000, date 0x004, time 0x008, scratch 0..3 at 0x020..0x02C. With variant 1 they are: control 0x000, date 0x010, time 0x014, scratch 0..7 at 0x100..0x11C. Every other offset is unmapped.
- R9: A `tick_1s` pulse increments the seconds field. A field at or above its limit wraps to zero and carries: seconds at 59 carry into minutes, minutes at 59 carry into hours, and hours at 23 wrap to zero. Bits [31:24] are preserved.
- R10: A bus write to the time word in the same cycle as a `tick_1s` pulse stores exactly the written value, and the tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (10) | Byte offset inside the window |
| bus_wdata | input | DATA_W (32) | Write data |
| tick_1s | input | 1 | One-cycle pulse that advances the time word |
| rd_data | output | DATA_W (32) | Read data, valid while `rd_valid` is high |
| rd_valid | output | 1 | Read data strobe, one cycle after a read |
| bus_err | output | 1 | Unmapped-access strobe, one cycle after the access |

## Verification
Two functions can land on the time word in the same cycle: a bus write and the seconds advance. The bench raises `tick_1s` in the same clock that carries a time-word write. It then reads the word back and requires the written value unchanged, not that value plus one. A later lone tick must still step the seconds, which shows the advance logic was only overridden and not broken.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // Which storage element a bus offset lands on
  typedef enum logic [2:0] {
    SLOT_NONE = 3'd0,
    SLOT_CTRL = 3'd1,
    SLOT_DATE = 3'd2,
    SLOT_TIME = 3'd3,
    SLOT_SCR  = 3'd4
  } slot_e;

  // Control-word flag positions (software polls these)
  localparam int FLAG_DATE_BIT = 7;
  localparam int FLAG_TIME_BIT = 8;

  // Time-word field layout
  localparam int FIELD_W  = 8;
  localparam int SEC_LSB  = 0;
  localparam int MIN_LSB  = 8;
  localparam int HOUR_LSB = 16;
  localparam int SEC_MAX  = 59;
  localparam int MIN_MAX  = 59;
  localparam int HOUR_MAX = 23;

  function automatic int scratch_count(input int variant);
    return (variant == 0) ? 4 : 8;
  endfunction

  function automatic int default_base_year(input int variant);
    return (variant == 0) ? 2010 : 1970;
  endfunction

endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
  import rtc_pkg::*;
#(
  parameter int MAP_VARIANT = 0,
  parameter int ADDR_W      = 10,
  parameter int SCR_N       = 4,
  parameter int SCR_IDX_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  output slot_e                slot,
  output logic [SCR_IDX_W-1:0] scr_idx
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              hit_ctrl, hit_date, hit_time, hit_scr;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  // Scratch bases are multiples of the bank size, so the low word bits index it
  assign scr_idx = word[SCR_IDX_W-1:0];

  generate
    if (MAP_VARIANT == 0) begin : g_map_compact
      localparam int CTRL_WORD = 0;
      localparam int DATE_WORD = 1;
      localparam int TIME_WORD = 2;
      localparam int SCR_BASE  = 8;
      assign hit_ctrl = aligned && (word == WORD_W'(CTRL_WORD));
      assign hit_date = aligned && (word == WORD_W'(DATE_WORD));
      assign hit_time = aligned && (word == WORD_W'(TIME_WORD));
      assign hit_scr  = aligned && (word >= WORD_W'(SCR_BASE))
                                && (word <  WORD_W'(SCR_BASE + SCR_N));
    end else begin : g_map_wide
      localparam int CTRL_WORD = 0;
      localparam int DATE_WORD = 4;
      localparam int TIME_WORD = 5;
      localparam int SCR_BASE  = 64;
      assign hit_ctrl = aligned && (word == WORD_W'(CTRL_WORD));
      assign hit_date = aligned && (word == WORD_W'(DATE_WORD));
      assign hit_time = aligned && (word == WORD_W'(TIME_WORD));
      assign hit_scr  = aligned && (word >= WORD_W'(SCR_BASE))
                                && (word <  WORD_W'(SCR_BASE + SCR_N));
    end
  endgenerate

  always_comb begin
    slot = SLOT_NONE;
    if (hit_ctrl)      slot = SLOT_CTRL;
    else if (hit_date) slot = SLOT_DATE;
    else if (hit_time) slot = SLOT_TIME;
    else if (hit_scr)  slot = SLOT_SCR;
  end

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_ctrl, hit_date, hit_time, hit_scr})); // R8

endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              date_we,
  input  logic              time_we,
  input  logic              ctrl_rd,
  input  logic              tick,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] date_q,
  output logic [DATA_W-1:0] time_q,
  output logic              flag_date_q,
  output logic              flag_time_q
);

  logic [DATA_W-1:0] time_adv;

  // Seconds -> minutes -> hours carry chain; fields at or above limit wrap
  always_comb begin
    logic [FIELD_W-1:0] s, m, h;
    s = time_q[SEC_LSB  +: FIELD_W];
    m = time_q[MIN_LSB  +: FIELD_W];
    h = time_q[HOUR_LSB +: FIELD_W];
    if (s >= FIELD_W'(SEC_MAX)) begin
      s = '0;
      if (m >= FIELD_W'(MIN_MAX)) begin
        m = '0;
        if (h >= FIELD_W'(HOUR_MAX)) h = '0;
        else                         h = h + 1'b1;
      end else begin
        m = m + 1'b1;
      end
    end else begin
      s = s + 1'b1;
    end
    time_adv = time_q;
    time_adv[SEC_LSB  +: FIELD_W] = s;
    time_adv[MIN_LSB  +: FIELD_W] = m;
    time_adv[HOUR_LSB +: FIELD_W] = h;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      date_q      <= '0;
      time_q      <= '0;
      flag_date_q <= 1'b0;
      flag_time_q <= 1'b0;
    end else begin
      if (date_we) date_q <= wdata;

      if (time_we)   time_q <= wdata;
      else if (tick) time_q <= time_adv;

      // A flag being set outranks a clearing read
      if (date_we)      flag_date_q <= 1'b1;
      else if (ctrl_rd) flag_date_q <= 1'b0;

      if (time_we)      flag_time_q <= 1'b1;
      else if (ctrl_rd) flag_time_q <= 1'b0;
    end
  end

  AST_DATE_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    date_we |=> flag_date_q); // R2
  AST_TIME_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    time_we |=> flag_time_q); // R2
  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rd && !date_we && !time_we) |=> (!flag_date_q && !flag_time_q)); // R3
  AST_TIME_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    time_we |=> (time_q == $past(wdata))); // R10
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !time_we && (time_q[SEC_LSB +: FIELD_W] < FIELD_W'(SEC_MAX)))
      |=> (time_q[SEC_LSB +: FIELD_W] == $past(time_q[SEC_LSB +: FIELD_W]) + 1'b1)); // R9

endmodule

// File: rtl/rtc_scratch_bank.sv
module rtc_scratch_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Registered read port; the stored words clear on reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (we) mem[idx] <= wdata;
      rdata_q <= mem[idx];
    end
  end

  AST_SCR_STORE: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(idx)] == $past(wdata))); // R6

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int MAP_VARIANT = 0,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 10,
  // Origin of the year field in the date word (documentation for software)
  parameter int BASE_YEAR   = default_base_year(MAP_VARIANT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              tick_1s,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              bus_err
);

  localparam int SCR_N     = scratch_count(MAP_VARIANT);
  localparam int SCR_IDX_W = $clog2(SCR_N);

  slot_e                slot;
  logic [SCR_IDX_W-1:0] scr_idx;
  logic                 rd_req, wr_req;
  logic                 date_we, time_we, ctrl_rd, scr_we;
  logic [DATA_W-1:0]    date_q, time_q, ctrl_word, scr_rdata;
  logic                 flag_date_q, flag_time_q;
  logic [DATA_W-1:0]    rd_hold_q;
  logic                 rd_from_scr_q, rd_valid_q, err_q;

  rtc_addr_decode #(
    .MAP_VARIANT (MAP_VARIANT),
    .ADDR_W      (ADDR_W),
    .SCR_N       (SCR_N),
    .SCR_IDX_W   (SCR_IDX_W)
  ) u_decode (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .slot    (slot),
    .scr_idx (scr_idx)
  );

  assign rd_req  = bus_sel && !bus_we;
  assign wr_req  = bus_sel &&  bus_we;
  assign date_we = wr_req && (slot == SLOT_DATE);
  assign time_we = wr_req && (slot == SLOT_TIME);
  assign scr_we  = wr_req && (slot == SLOT_SCR);
  assign ctrl_rd = rd_req && (slot == SLOT_CTRL);

  rtc_time_regs #(.DATA_W(DATA_W)) u_time (
    .clk         (clk),
    .rst         (rst),
    .date_we     (date_we),
    .time_we     (time_we),
    .ctrl_rd     (ctrl_rd),
    .tick        (tick_1s),
    .wdata       (bus_wdata),
    .date_q      (date_q),
    .time_q      (time_q),
    .flag_date_q (flag_date_q),
    .flag_time_q (flag_time_q)
  );

  rtc_scratch_bank #(
    .DATA_W (DATA_W),
    .DEPTH  (SCR_N),
    .IDX_W  (SCR_IDX_W)
  ) u_scratch (
    .clk     (clk),
    .rst     (rst),
    .we      (scr_we),
    .idx     (scr_idx),
    .wdata   (bus_wdata),
    .rdata_q (scr_rdata)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[FLAG_DATE_BIT] = flag_date_q;
    ctrl_word[FLAG_TIME_BIT] = flag_time_q;
  end

  // Snapshot is taken at the access edge, before the flags clear
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hold_q     <= '0;
      rd_from_scr_q <= 1'b0;
      rd_valid_q    <= 1'b0;
      err_q         <= 1'b0;
    end else begin
      rd_valid_q    <= rd_req;
      err_q         <= bus_sel && (slot == SLOT_NONE);
      rd_from_scr_q <= rd_req && (slot == SLOT_SCR);
      if (rd_req) begin
        unique case (slot)
          SLOT_CTRL: rd_hold_q <= ctrl_word;
          SLOT_DATE: rd_hold_q <= date_q;
          SLOT_TIME: rd_hold_q <= time_q;
          default:   rd_hold_q <= '0;
        endcase
      end
    end
  end

  assign rd_data  = rd_from_scr_q ? scr_rdata : rd_hold_q;
  assign rd_valid = rd_valid_q;
  assign bus_err  = err_q;

  AST_READ_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid); // R5
  AST_NO_VALID_WITHOUT_READ: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid); // R5
  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && bus_err) |-> (rd_data == '0)); // R7
  AST_UNMAPPED_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (wr_req && (slot == SLOT_NONE)) |=> ($stable(ctrl_word) && $stable(date_q) && $stable(time_q)) || $past(tick_1s)); // R7
  AST_CTRL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_req && (slot == SLOT_CTRL)) |=> $stable(ctrl_word)); // R4

endmodule

// File: tb/test_rtc_regfile.sv
`timescale 1ns/1ps
module test_rtc_regfile;

  localparam int DW = 32;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel = 1'b0;
  logic          we  = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          tick = 1'b0;

  logic [DW-1:0] rd_a, rd_b;
  logic          vld_a, vld_b, err_a, err_b;

  // Captured results of the last access
  logic [DW-1:0] ra, rb;
  logic          va, vb, ea, eb;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rtc_regfile #(.MAP_VARIANT(0)) i_rtc_regfile (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .tick_1s(tick), .rd_data(rd_a), .rd_valid(vld_a), .bus_err(err_a));

  rtc_regfile #(.MAP_VARIANT(1)) i_rtc_regfile_b (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .tick_1s(tick), .rd_data(rd_b), .rd_valid(vld_b), .bus_err(err_b));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic capture();
    ra = rd_a; rb = rd_b; va = vld_a; vb = vld_b; ea = err_a; eb = err_b;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; capture();
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic with_tick);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d; tick = with_tick;
    @(negedge clk); sel = 1'b0; we = 1'b0; tick = 1'b0; capture();
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd_valid low after reset", {31'd0, vld_a}, 32'd0);
    chk("R1 bus_err low after reset", {31'd0, err_a}, 32'd0);
    do_read(10'h000); chk("R1 control zero", ra, 32'd0);
    do_read(10'h004); chk("R1 date zero", ra, 32'd0);
    do_read(10'h008); chk("R1 time zero", ra, 32'd0);
    do_read(10'h020); chk("R1 scratch0 zero", ra, 32'd0);
    do_read(10'h100); chk("R1 variant1 scratch0 zero", rb, 32'd0);
  endtask

  task automatic t_flags();
    do_write(10'h004, 32'h000E_0C1F, 1'b0);
    chk("R2 date write no error", {31'd0, ea}, 32'd0);
    do_read(10'h004); chk("R2 date stored", ra, 32'h000E_0C1F);
    do_read(10'h020); chk("R6 scratch read", ra, 32'd0);
    do_read(10'h000); chk("R2 R6 date flag bit7", ra, 32'h0000_0080);
    do_read(10'h000); chk("R3 flags cleared by read", ra, 32'd0);
    do_write(10'h008, 32'h4011_2233, 1'b0);
    do_read(10'h008); chk("R2 time stored", ra, 32'h4011_2233);
    do_read(10'h000); chk("R2 time flag bit8", ra, 32'h0000_0100);
    do_write(10'h004, 32'h0001_0101, 1'b0);
    do_write(10'h008, 32'h0000_0000, 1'b0);
    do_read(10'h000); chk("R3 both flags returned", ra, 32'h0000_0180);
    do_read(10'h000); chk("R3 both flags cleared", ra, 32'd0);
  endtask

  task automatic t_ctrl_write();
    do_write(10'h004, 32'h0002_0304, 1'b0);
    do_write(10'h000, 32'hFFFF_FFFF, 1'b0);
    chk("R4 control write not an error", {31'd0, ea}, 32'd0);
    do_read(10'h000); chk("R4 control write ignored", ra, 32'h0000_0080);
    do_read(10'h000); chk("R4 flags cleared after", ra, 32'd0);
  endtask

  task automatic t_latency();
    do_write(10'h020, 32'h1234_5678, 1'b0);
    chk("R5 no rd_valid on write", {31'd0, va}, 32'd0);
    do_read(10'h020);
    chk("R5 rd_valid one cycle after read", {31'd0, va}, 32'd1);
    chk("R5 data with rd_valid", ra, 32'h1234_5678);
    @(negedge clk);
    chk("R5 rd_valid single cycle", {31'd0, vld_a}, 32'd0);
  endtask

  task automatic t_scratch();
    for (int i = 0; i < 4; i++)
      do_write(AW'(32'h020 + 4 * i), 32'hA5A5_0000 + 32'(i), 1'b0);
    for (int i = 0; i < 4; i++) begin
      do_read(AW'(32'h020 + 4 * i));
      chk("R6 scratch readback", ra, 32'hA5A5_0000 + 32'(i));
    end
    do_read(10'h000); chk("R6 scratch leaves flags", ra, 32'd0);
  endtask

  task automatic t_unmapped();
    do_write(10'h00C, 32'hDEAD_BEEF, 1'b0);
    chk("R7 write hole error", {31'd0, ea}, 32'd1);
    do_read(10'h00C);
    chk("R7 read hole zero", ra, 32'd0);
    chk("R7 read hole error", {31'd0, ea}, 32'd1);
    do_write(10'h005, 32'hFFFF_FFFF, 1'b0);
    chk("R7 unaligned write error", {31'd0, ea}, 32'd1);
    do_read(10'h004); chk("R7 date untouched", ra, 32'h0002_0304);
    chk("R7 no error on mapped read", {31'd0, ea}, 32'd0);
    do_write(10'h030, 32'h0BAD_0BAD, 1'b0);
    chk("R8 scratch4 absent in variant0", {31'd0, ea}, 32'd1);
    do_read(10'h3FC); chk("R7 top of window zero", ra, 32'd0);
    do_read(10'h000); chk("R7 no flags from bad writes", ra, 32'd0);
  endtask

  task automatic t_variant_b();
    do_read(10'h000);
    do_write(10'h010, 32'h0036_0715, 1'b0);
    chk("R8 variant1 date mapped", {31'd0, eb}, 32'd0);
    chk("R8 0x010 hole in variant0", {31'd0, ea}, 32'd1);
    do_write(10'h014, 32'h2008_090A, 1'b0);
    do_read(10'h010); chk("R8 variant1 date", rb, 32'h0036_0715);
    do_read(10'h014); chk("R8 variant1 time", rb, 32'h2008_090A);
    do_read(10'h000); chk("R8 R3 variant1 flags", rb, 32'h0000_0180);
    for (int i = 0; i < 8; i++)
      do_write(AW'(32'h100 + 4 * i), 32'h5A00_0000 + 32'(i * 3), 1'b0);
    for (int i = 0; i < 8; i++) begin
      do_read(AW'(32'h100 + 4 * i));
      chk("R8 variant1 scratch", rb, 32'h5A00_0000 + 32'(i * 3));
    end
    do_read(10'h004);
    chk("R8 0x004 hole in variant1", {31'd0, eb}, 32'd1);
    chk("R8 hole reads zero variant1", rb, 32'd0);
  endtask

  task automatic t_tick();
    do_write(10'h008, 32'h600A_141E, 1'b0); pulse_tick();
    do_read(10'h008); chk("R9 seconds step", ra, 32'h600A_141F);
    do_write(10'h008, 32'hC017_3B3B, 1'b0); pulse_tick();
    do_read(10'h008); chk("R9 midnight wrap keeps weekday", ra, 32'hC000_0000);
    do_write(10'h008, 32'h000C_223B, 1'b0); pulse_tick();
    do_read(10'h008); chk("R9 minute carry", ra, 32'h000C_2300);
    do_write(10'h008, 32'h0005_3B3B, 1'b0); pulse_tick();
    do_read(10'h008); chk("R9 hour carry", ra, 32'h0006_0000);
    do_read(10'h004); chk("R9 date unaffected", ra, 32'h0002_0304);
  endtask

  task automatic t_collide();
    do_write(10'h008, 32'h0000_0000, 1'b0);
    pulse_tick();
    do_write(10'h008, 32'h0001_0203, 1'b1);
    do_read(10'h008); chk("R10 write beats tick", ra, 32'h0001_0203);
    pulse_tick();
    do_read(10'h008); chk("R10 tick still works after", ra, 32'h0001_0204);
    do_read(10'h000); chk("R10 time flag set", ra, 32'h0000_0100);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    capture();
    t_reset();
    t_flags();
    t_ctrl_write();
    t_latency();
    t_scratch();
    t_unmapped();
    t_variant_b();
    t_tick();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule